// File: doc/BRIEF.md
# Oscillator Frequency-Ratio Meter

This block measures how fast one free-running clock runs compared with another and reports the answer as an 11-bit count. A reference clock times a measurement window 512 of its own periods long. While the window is open, every rising edge of a second, measured clock is counted. The count therefore approaches 512 × f_meas / f_ref and does not depend on the absolute speed of either source. Two on-die ring oscillators with different temperature and process slopes are the intended sources. The block itself treats them as plain clock inputs.

A control unit on the system clock starts a conversion on a rising edge of `start`. It raises `osc_en` to let both oscillators run and waits until the window has closed and the count has stopped. It then lowers `osc_en` and, after a fixed settling delay, raises `ready`. The block spans three clock domains: the system clock, the reference clock and the measured clock. Every crossing between them goes through a multi-flop synchronizer. `result` keeps its value from the moment `ready` rises until the next conversion opens its window.

Top module: `freq_ratio_meter`

## Requirements
- R1: After reset, `ready` is 0, `osc_en` is 0 and `result` is 0.
- R2: A rising edge of `start` seen while the block is idle starts a conversion. `ready` is 0 at the first system-clock edge after that rising edge is sampled.
- R3: `osc_en` is 1 while the measurement window is running, and it is 0 again by the time `ready` rises.
- R4: The window lasts exactly 512 reference-clock periods. The finished `result` is within ±1 of 512 × f_meas / f_ref. `ready` does not rise before 512 reference periods have elapsed after the start edge.
- R5: `ready` rises only after the count has stopped changing. While `ready` stays high, `result` holds a constant value.
- R6: A rising edge of `start` that arrives while a conversion is running is ignored. That conversion ends at its normal time with its normal result.
- R7: When more than 2047 measured edges fall inside the window, `result` stays at 2047 and does not wrap.
- R8: Holding `start` high does not start another conversion. A new conversion needs a fresh low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the control unit |
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| start | input | 1 | Conversion request, synchronous to clk; acts on its rising edge |
| ref_clk | input | 1 | Reference oscillator; times the 512-period window |
| meas_clk | input | 1 | Measured oscillator; its edges are counted |
| osc_en | output | 1 | Oscillator enable, high during a conversion |
| ready | output | 1 | Result valid |
| result | output | 11 | Count of measured edges in the window, saturating |

## Verification
The hardest condition to reach from the ports is a close race between the end of the window and the reporting of the result. It happens when the measured clock is much slower than the system clock, or when the two oscillators run at nearly the same rate. If the control unit trusted only the reference-domain window-end flag, `ready` could rise while the measured-domain counter was still taking edges. The stimulus reaches this race by changing both oscillator periods between conversions, mixing seeded random period pairs with directed ones: equal periods, a measured clock that is slower than the reference, and ratios at and above saturation. After each conversion it watches `result` for many cycles with `ready` held high. It also fires a second `start` edge in the middle of one window and holds `start` high through another conversion.

// File: rtl/frm_pkg.sv
package frm_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_CLR,
      S_DRAIN,
      S_RUN,
      S_SETTLE
   } frm_state_e;
endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("frm_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/frm_window.sv
module frm_window #(
   parameter int WIN_W  = 10,
   parameter int STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic arm,
   output logic win,
   output logic done
);
   localparam int          MSB  = WIN_W - 1;
   localparam logic [WIN_W-1:0] HALF = WIN_W'(1) << MSB;

   logic             arm_r;
   logic [WIN_W-1:0] cnt, cnt_nxt;
   logic             win_q;

   frm_sync #(.STAGES(STAGES)) u_arm_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(arm), .q(arm_r)
   );

   always_comb begin
      if (!arm_r)                cnt_nxt = '0;
      else if (win_q && !cnt[MSB]) cnt_nxt = cnt + WIN_W'(1);
      else                       cnt_nxt = cnt;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         win_q <= 1'b0;
      end else begin
         cnt   <= cnt_nxt;
         win_q <= arm_r && !cnt_nxt[MSB];
      end
   end

   assign win  = win_q;
   assign done = cnt[MSB];

   assert_window_len_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cnt <= HALF);
   assert_window_shut_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      done |-> !win);
endmodule

// File: rtl/frm_count.sv
module frm_count #(
   parameter int RES_W    = 11,
   parameter int STAGES   = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic             meas_clk,
   input  logic             rst_n,
   input  logic             win,
   output logic             busy,
   output logic [RES_W-1:0] count
);
   localparam logic [RES_W-1:0] MAXV = {RES_W{1'b1}};

   logic             win_m, win_d;
   logic [RES_W-1:0] cnt, step;

   frm_sync #(.STAGES(STAGES)) u_win_sync (
      .clk(meas_clk), .rst_n(rst_n), .d(win), .q(win_m)
   );

   generate
      if (SATURATE) begin : g_sat
         assign step = (cnt == MAXV) ? cnt : cnt + RES_W'(1);
      end else begin : g_wrap
         assign step = cnt + RES_W'(1);
      end
   endgenerate

   always_ff @(posedge meas_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         win_d <= 1'b0;
      end else begin
         win_d <= win_m;
         if (win_m && !win_d) cnt <= RES_W'(1);
         else if (win_m)      cnt <= step;
      end
   end

   assign busy  = win_m;
   assign count = cnt;

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_overflow_R7: assert property (@(posedge meas_clk) disable iff (!rst_n)
            (cnt == MAXV && win_m && win_d) |=> (cnt == MAXV));
      end
   endgenerate

   assert_frozen_R5: assert property (@(posedge meas_clk) disable iff (!rst_n)
      !win_m |=> $stable(cnt));
endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
   import frm_pkg::*;
#(
   parameter int SETTLE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done_s,
   input  logic busy_s,
   output logic arm,
   output logic osc_en,
   output logic ready
);
   localparam int SCW = $clog2(SETTLE + 1);

   frm_state_e     state;
   logic           start_d;
   logic           start_rise;
   logic [SCW-1:0] settle_cnt;

   assign start_rise = start && !start_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         start_d    <= 1'b0;
         ready      <= 1'b0;
         settle_cnt <= '0;
      end else begin
         start_d <= start;
         case (state)
            S_IDLE: if (start_rise) begin
               state <= S_CLR;
               ready <= 1'b0;
            end
            S_CLR: state <= S_DRAIN;
            S_DRAIN: if (!done_s && !busy_s) state <= S_RUN;
            S_RUN: if (done_s && !busy_s) begin
               state      <= S_SETTLE;
               settle_cnt <= '0;
            end
            S_SETTLE: begin
               if (settle_cnt == SCW'(SETTLE - 1)) begin
                  state <= S_IDLE;
                  ready <= 1'b1;
               end else begin
                  settle_cnt <= settle_cnt + SCW'(1);
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign arm    = (state == S_RUN);
   assign osc_en = arm;

   assert_ready_after_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (!busy_s && !osc_en));
   assert_osc_vs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en |-> !ready);
   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && start_rise) |=> (state == S_RUN || state == S_SETTLE));
   assert_clear_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CLR) |=> (state == S_DRAIN && !ready));
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter #(
   parameter int WIN_W    = 10,
   parameter int RES_W    = 11,
   parameter int STAGES   = 2,
   parameter int SETTLE   = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ref_clk,
   input  logic             meas_clk,
   output logic             osc_en,
   output logic             ready,
   output logic [RES_W-1:0] result
);
   logic arm, win, done, busy, done_s, busy_s;

   generate
      if (WIN_W < 2) begin : g_bad_win
         $error("WIN_W must be at least 2");
      end
      if (RES_W < WIN_W) begin : g_bad_res
         $error("RES_W must not be narrower than WIN_W");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("SETTLE must be at least 1");
      end
   endgenerate

   frm_ctrl #(.SETTLE(SETTLE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .done_s(done_s), .busy_s(busy_s),
      .arm(arm), .osc_en(osc_en), .ready(ready)
   );

   frm_window #(.WIN_W(WIN_W), .STAGES(STAGES)) u_win (
      .ref_clk(ref_clk), .rst_n(rst_n), .arm(arm), .win(win), .done(done)
   );

   frm_count #(.RES_W(RES_W), .STAGES(STAGES), .SATURATE(SATURATE)) u_cnt (
      .meas_clk(meas_clk), .rst_n(rst_n), .win(win), .busy(busy), .count(result)
   );

   frm_sync #(.STAGES(STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done), .q(done_s)
   );

   frm_sync #(.STAGES(STAGES)) u_busy_sync (
      .clk(clk), .rst_n(rst_n), .d(busy), .q(busy_s)
   );
endmodule

// File: tb/sim_freq_ratio_meter.sv
`timescale 1ns/1ps
module sim_freq_ratio_meter;
   logic clk = 1'b0, ref_clk = 1'b0, meas_clk = 1'b0;
   logic rst_n = 1'b0, start = 1'b0;
   logic osc_en, ready;
   logic [10:0] result;

   real ref_half  = 5.0;
   real meas_half = 5.0;
   int  checks = 0;
   int  fails  = 0;
   bit  done_flag = 1'b0;

   always #2 clk = ~clk;
   always #(ref_half)  ref_clk  = ~ref_clk;
   always #(meas_half) meas_clk = ~meas_clk;

   freq_ratio_meter u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_clk(ref_clk),
      .meas_clk(meas_clk), .osc_en(osc_en), .ready(ready), .result(result)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic real expected_count(input real tr, input real tm);
      real e;
      e = 512.0 * tr / tm;
      return (e > 2047.0) ? 2047.0 : e;
   endfunction

   task automatic run_conv(input real tr, input real tm, input bit hold_start,
                           input bit extra_pulse);
      real t0, el, e, d;
      int  n, r0;
      bit  bad;
      ref_half  = tr / 2.0;
      meas_half = tm / 2.0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      t0 = $realtime;
      @(negedge clk);
      check(ready == 1'b0, "R2", "ready after start edge", int'(ready), 0);
      if (!hold_start) start = 1'b0;
      repeat (100) @(negedge clk);
      check(osc_en == 1'b1, "R3", "osc_en during window", int'(osc_en), 1);
      if (extra_pulse) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!ready && n < 20000) begin
         @(negedge clk);
         n++;
      end
      el = $realtime - t0;
      check(ready == 1'b1, "R4", "ready reached", int'(ready), 1);
      check(el >= 512.0 * tr, "R4", "ready not before window end (ns)",
            int'(el), int'(512.0 * tr));
      check(el <= 512.0 * tr + 400.0, extra_pulse ? "R6" : "R4",
            "conversion time (ns)", int'(el), int'(512.0 * tr));
      e = expected_count(tr, tm);
      d = real'(result) - e;
      if (d < 0.0) d = -d;
      check(d <= 1.0, (512.0 * tr / tm > 2047.0) ? "R7" : "R4",
            "result", int'(result), int'(e));
      check(osc_en == 1'b0, "R3", "osc_en at ready", int'(osc_en), 0);
      r0 = int'(result);
      bad = 1'b0;
      repeat (16) begin
         @(negedge clk);
         if (int'(result) != r0 || !ready) bad = 1'b1;
      end
      check(!bad, "R5", "result stable while ready", int'(result), r0);
      if (hold_start) begin
         repeat (100) @(negedge clk);
         check(ready == 1'b1 && osc_en == 1'b0, "R8", "no retrigger on held start",
               int'(osc_en), 0);
         start = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd5150);
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b0, "R1", "ready after reset", int'(ready), 0);
      check(osc_en == 1'b0, "R1", "osc_en after reset", int'(osc_en), 0);
      check(result == 11'd0, "R1", "result after reset", int'(result), 0);

      run_conv(10.0, 10.0, 1'b0, 1'b0);
      run_conv(10.0, 20.0, 1'b0, 1'b0);
      run_conv(8.0,  3.0,  1'b0, 1'b0);
      run_conv(12.0, 7.0,  1'b0, 1'b1);
      run_conv(9.0,  11.0, 1'b1, 1'b0);
      run_conv(20.0, 4.0,  1'b0, 1'b0);
      run_conv(16.0, 4.0,  1'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         real tr, tm;
         tr = real'($urandom_range(50, 200)) / 10.0;
         tm = real'($urandom_range(30, 300)) / 10.0;
         run_conv(tr, tm, 1'b0, (i % 3) == 1);
      end
      done_flag = 1'b1;
      summary();
      $finish;
   end
endmodule